// File: doc/BRIEF.md
# Regulator Power-Up Sequencer

This block steps a multi-phase buck regulator controller from off to power-good. Nothing happens until the enable input and the supply-above-lockout input are both high. A fixed delay comes first. A short window follows in which the phase count is detected, and the PWM stages stay blanked through both. The reference code then ramps from zero to a fixed boot level and holds there. At the end of the hold the VID code is captured once, and the reference ramps up or down to it. Power-good rises after a masking interval and a final blanking interval.

Every duration is counted in pulses of a timebase tick (nominally one millisecond). The detect window is the one exception: it counts pulses of the switching-clock strobe. All durations are parameters, so a short simulation can use small values. Losing enable or the supply at any point sends the block straight back to idle.

Top module: `vr_pwrup_seq`

## Requirements
- R1: The sequence starts only while `en` and `uvlo_ok` are both high. With either one low, the outputs keep their idle values: `pwm_blank`=1, `detect_win`=0, `ss_active`=0, `pwr_good`=0, `dac_code`=0.
- R2: After the start, a delay stage lasts exactly `DELAY_TICKS` timebase ticks. During it `pwm_blank`=1 and `dac_code`=0.
- R3: The detect stage follows. `detect_win`=1 and `pwm_blank`=1 for exactly `DETECT_CYCLES` pulses of `sw_tick`.
- R4: In the boot ramp, `ss_active`=1 and `pwm_blank`=0. `dac_code` starts at 0 and rises by exactly one LSB every `STEP_TICKS` ticks until it equals `BOOT_CODE`.
- R5: `dac_code` then holds `BOOT_CODE` with `ss_active`=0 for exactly `HOLD_TICKS` ticks. Changes on `vid` during this time do not move `dac_code`.
- R6: `vid` is captured once, when the hold stage ends. `dac_code` then moves one LSB per `STEP_TICKS` ticks, up or down, until it equals the captured value. Later changes on `vid` have no effect.
- R7: After the target is reached, `ss_active` drops. `pwr_good` rises after exactly `MASK_TICKS`+`BLANK_TICKS` further ticks and stays high.
- R8: Reset leaves the idle outputs. If `en` or `uvlo_ok` is low at a clock edge, then from the next cycle the outputs are idle (`pwm_blank`=1, `pwr_good`=0, `dac_code`=0) in any stage.
- R9: If the captured VID equals `BOOT_CODE`, the second ramp lasts one cycle and moves no code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle timebase pulse |
| sw_tick | input | 1 | One-cycle switching-clock strobe |
| en | input | 1 | Regulator enable |
| uvlo_ok | input | 1 | Supply above lockout threshold |
| vid | input | 8 | Target reference code |
| dac_code | output | 8 | Ramped reference code |
| pwm_blank | output | 1 | Holds PWM stages inactive |
| detect_win | output | 1 | Phase-count detection window |
| ss_active | output | 1 | A reference ramp is in progress |
| pwr_good | output | 1 | Output is in regulation |

## Verification
A wrong stage or an early exit from a stage shows at the ports within one cycle. It appears as a change in the output tuple that the scoreboard did not expect, or one that comes after the wrong number of ticks. A bad ramp counter shows as a code step arriving at the wrong tick count, or as a step of more than one LSB. A wrong VID capture shows as a final code that differs from the value present at the end of the hold. The scoreboard records each change together with the ticks that passed before it, so a timer that is off by one fails on the first transition it governs.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DELAY,
    ST_DETECT,
    ST_RAMP_BOOT,
    ST_HOLD,
    ST_RAMP_VID,
    ST_MASK,
    ST_BLANK,
    ST_GOOD
  } seq_state_e;
endpackage

// File: rtl/vrseq_timer.sv
module vrseq_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = run && tick && (cnt_q == limit - 1'b1);
    cnt_d = cnt_q;
    if (!run || done) cnt_d = '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the stage count never reaches its limit while the stage is running
  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned STEP_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic              tick,
  input  logic [CODE_W-1:0] target,
  output logic [CODE_W-1:0] code,
  output logic              at_target
);
  localparam int unsigned DW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;

  logic [DW-1:0]     div_q, div_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic              step;

  always_comb begin
    at_target = (code_q == target);
    step      = run && tick && !at_target && (div_q == DW'(STEP_TICKS - 1));
    div_d     = div_q;
    if (!run || at_target) div_d = '0;
    else if (step)         div_d = '0;
    else if (tick)         div_d = div_q + 1'b1;
    code_d = code_q;
    if (clr)                        code_d = '0;
    else if (step && code_q < target) code_d = code_q + 1'b1;
    else if (step)                  code_d = code_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      code_q <= '0;
    end else begin
      div_q  <= div_d;
      code_q <= code_d;
    end
  end

  assign code = code_q;

  // R4: a running ramp moves the code by at most one LSB per cycle
  p_one_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> ((code_q == $past(code_q) + 1'b1) ||
                       (code_q == $past(code_q) - 1'b1) ||
                       (code_q == $past(code_q))));

  // R6: an upward ramp never passes its target
  p_no_overshoot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && (code_q < target)) |=> (code_q <= $past(target)));
endmodule

// File: rtl/vrseq_ctrl.sv
module vrseq_ctrl
  import vrseq_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              tmr_done,
  input  logic              det_done,
  input  logic              at_target,
  input  logic [CODE_W-1:0] vid,
  output seq_state_e        state,
  output logic [CODE_W-1:0] vid_lat
);
  seq_state_e        state_q, state_d;
  logic [CODE_W-1:0] vid_q;
  logic              cap_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (go)        state_d = ST_DELAY;
      ST_DELAY:     if (tmr_done)  state_d = ST_DETECT;
      ST_DETECT:    if (det_done)  state_d = ST_RAMP_BOOT;
      ST_RAMP_BOOT: if (at_target) state_d = ST_HOLD;
      ST_HOLD:      if (tmr_done)  state_d = ST_RAMP_VID;
      ST_RAMP_VID:  if (at_target) state_d = ST_MASK;
      ST_MASK:      if (tmr_done)  state_d = ST_BLANK;
      ST_BLANK:     if (tmr_done)  state_d = ST_GOOD;
      ST_GOOD:                     state_d = ST_GOOD;
      default:                     state_d = ST_IDLE;
    endcase
    if (!go) state_d = ST_IDLE;
    cap_en = go && (state_q == ST_HOLD) && tmr_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vid_q <= '0;
    else if (cap_en) vid_q <= vid;
  end

  assign state   = state_q;
  assign vid_lat = vid_q;

  // R7: the good state is entered only from the blanking stage
  p_good_from_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GOOD && $past(state_q) != ST_GOOD) |-> ($past(state_q) == ST_BLANK));

  // R1: leaving idle requires both start conditions at that edge
  p_start_needs_go_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !go) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/vr_pwrup_seq.sv
module vr_pwrup_seq
  import vrseq_pkg::*;
#(
  parameter int unsigned CODE_W        = 8,
  parameter int unsigned DELAY_TICKS   = 2,
  parameter int unsigned DETECT_CYCLES = 6,
  parameter int unsigned HOLD_TICKS    = 2,
  parameter int unsigned MASK_TICKS    = 1,
  parameter int unsigned BLANK_TICKS   = 3,
  parameter int unsigned STEP_TICKS    = 1,
  parameter int unsigned BOOT_CODE     = 110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              sw_tick,
  input  logic              en,
  input  logic              uvlo_ok,
  input  logic [CODE_W-1:0] vid,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwm_blank,
  output logic              detect_win,
  output logic              ss_active,
  output logic              pwr_good
);
  localparam int unsigned MAX_A = (DELAY_TICKS > HOLD_TICKS ? DELAY_TICKS : HOLD_TICKS) >
                                  (MASK_TICKS > BLANK_TICKS ? MASK_TICKS : BLANK_TICKS) ?
                                  (DELAY_TICKS > HOLD_TICKS ? DELAY_TICKS : HOLD_TICKS) :
                                  (MASK_TICKS > BLANK_TICKS ? MASK_TICKS : BLANK_TICKS);
  localparam int unsigned AW = $clog2(MAX_A + 1);
  localparam int unsigned DW = $clog2(DETECT_CYCLES + 1);
  localparam logic [CODE_W-1:0] BOOT = CODE_W'(BOOT_CODE);

  seq_state_e        state;
  logic [CODE_W-1:0] vid_lat, target;
  logic [AW-1:0]     lim_a;
  logic              go, run_a, done_a, run_d, done_d, ramp_run, ramp_clr, at_target;

  assign go = en && uvlo_ok;

  always_comb begin
    run_a = 1'b1;
    lim_a = AW'(DELAY_TICKS);
    unique case (state)
      ST_DELAY: lim_a = AW'(DELAY_TICKS);
      ST_HOLD:  lim_a = AW'(HOLD_TICKS);
      ST_MASK:  lim_a = AW'(MASK_TICKS);
      ST_BLANK: lim_a = AW'(BLANK_TICKS);
      default:  run_a = 1'b0;
    endcase
    run_d    = (state == ST_DETECT);
    ramp_run = (state == ST_RAMP_BOOT) || (state == ST_RAMP_VID);
    ramp_clr = !go || (state == ST_IDLE) || (state == ST_DELAY) || (state == ST_DETECT);
    target   = (state == ST_RAMP_VID) ? vid_lat : BOOT;
  end

  vrseq_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .go(go), .tmr_done(done_a), .det_done(done_d),
    .at_target(at_target), .vid(vid), .state(state), .vid_lat(vid_lat)
  );

  vrseq_timer #(.CW(AW)) u_stage_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_a), .tick(ms_tick), .limit(lim_a), .done(done_a)
  );

  vrseq_timer #(.CW(DW)) u_detect_tmr (
    .clk(clk), .rst_n(rst_n), .run(run_d), .tick(sw_tick),
    .limit(DW'(DETECT_CYCLES)), .done(done_d)
  );

  vrseq_ramp #(.CODE_W(CODE_W), .STEP_TICKS(STEP_TICKS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clr(ramp_clr), .run(ramp_run), .tick(ms_tick),
    .target(target), .code(dac_code), .at_target(at_target)
  );

  assign pwm_blank  = (state == ST_IDLE) || (state == ST_DELAY) || (state == ST_DETECT);
  assign detect_win = (state == ST_DETECT);
  assign ss_active  = ramp_run;
  assign pwr_good   = (state == ST_GOOD);

  // R8: losing either start condition idles the outputs on the next cycle
  p_drop_idles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!pwr_good && pwm_blank && dac_code == '0));

  // R3: the reference stays at zero while the detect window is open
  p_zero_in_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    detect_win |-> (dac_code == '0));
endmodule

// File: tb/tb_vr_pwrup_seq.sv
module tb_vr_pwrup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 4, DET = 6, HOLD = 3, MASK = 2, BLNK = 2, STEP = 2, BOOT = 6;

  typedef struct {
    bit blank; bit det; bit ss; bit pg; int code; int ticks; int sws; string tag;
  } exp_t;

  logic clk = 0, rst_n, ms_tick = 0, sw_tick = 0, en, uvlo_ok;
  logic [7:0] vid, dac_code;
  logic pwm_blank, detect_win, ss_active, pwr_good;

  exp_t q[$];
  int n_checks = 0, n_fail = 0;
  bit clr_req = 0;
  int ms_cnt = 0, sw_cnt = 0;
  logic [11:0] prev = {1'b1, 1'b0, 1'b0, 1'b0, 8'd0};

  always #(CLK_PERIOD/2) clk = ~clk;

  vr_pwrup_seq #(.DELAY_TICKS(DLY), .DETECT_CYCLES(DET), .HOLD_TICKS(HOLD),
                 .MASK_TICKS(MASK), .BLANK_TICKS(BLNK), .STEP_TICKS(STEP),
                 .BOOT_CODE(BOOT)) dut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .sw_tick(sw_tick), .en(en),
    .uvlo_ok(uvlo_ok), .vid(vid), .dac_code(dac_code), .pwm_blank(pwm_blank),
    .detect_win(detect_win), .ss_active(ss_active), .pwr_good(pwr_good));

  int div_ms = 0, div_sw = 0;
  always @(posedge clk) begin
    #1;
    div_ms = (div_ms == 4) ? 0 : div_ms + 1;
    div_sw = (div_sw == 1) ? 0 : div_sw + 1;
    ms_tick = (div_ms == 0);
    sw_tick = (div_sw == 0);
  end

  task automatic push(bit b, bit d, bit s, bit p, int c, int t, int w, string tag);
    exp_t e;
    e.blank = b; e.det = d; e.ss = s; e.pg = p; e.code = c; e.ticks = t; e.sws = w; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic push_startup(int v);
    push(1, 1, 0, 0, 0, DLY, -1, "R2");
    push(0, 0, 1, 0, 0, -1, DET, "R3");
    for (int c = 1; c <= BOOT; c++) push(0, 0, 1, 0, c, STEP, -1, "R4");
    push(0, 0, 0, 0, BOOT, -1, -1, "R5");
    push(0, 0, 1, 0, BOOT, HOLD, -1, "R5");
    if (v > BOOT) for (int c = BOOT + 1; c <= v; c++) push(0, 0, 1, 0, c, STEP, -1, "R6");
    if (v < BOOT) for (int c = BOOT - 1; c >= v; c--) push(0, 0, 1, 0, c, STEP, -1, "R6");
    push(0, 0, 0, 0, v, -1, -1, (v == BOOT) ? "R9" : "R6");
    push(0, 0, 0, 1, v, MASK + BLNK, -1, "R7");
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check_idle(string tag);
    n_checks++;
    if (!(pwm_blank && !detect_win && !ss_active && !pwr_good && dac_code == 0)) begin
      n_fail++;
      $display("FAIL %s idle outputs: actual blank=%0b det=%0b ss=%0b pg=%0b code=%0d expected 1 0 0 0 0",
               tag, pwm_blank, detect_win, ss_active, pwr_good, dac_code);
    end
  endtask

  task automatic drain();
    while (q.size() > 0) cyc();
    repeat (40) cyc();
  endtask

  // Monitor: compare every change in the output tuple against the queue
  always @(negedge clk) begin
    logic [11:0] cur;
    exp_t e;
    if (rst_n) begin
      cur = {pwm_blank, detect_win, ss_active, pwr_good, dac_code};
      if (clr_req) begin
        ms_cnt = 0; sw_cnt = 0; clr_req = 0;
      end else if (cur != prev) begin
        n_checks++;
        if (q.size() == 0) begin
          n_fail++;
          $display("FAIL R1 unexpected change: actual %h expected no change", cur);
        end else begin
          e = q.pop_front();
          if (cur != {e.blank, e.det, e.ss, e.pg, 8'(e.code)} ||
              (e.ticks >= 0 && e.ticks != ms_cnt) || (e.sws >= 0 && e.sws != sw_cnt)) begin
            n_fail++;
            $display("FAIL %s: actual blank=%0b det=%0b ss=%0b pg=%0b code=%0d ticks=%0d sw=%0d expected %0b %0b %0b %0b code=%0d ticks=%0d sw=%0d",
                     e.tag, cur[11], cur[10], cur[9], cur[8], cur[7:0], ms_cnt, sw_cnt,
                     e.blank, e.det, e.ss, e.pg, e.code, e.ticks, e.sws);
          end
        end
        ms_cnt = int'(ms_tick); sw_cnt = int'(sw_tick);
      end else begin
        ms_cnt += int'(ms_tick); sw_cnt += int'(sw_tick);
      end
      prev = cur;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog: actual=hung expected=sequence complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; uvlo_ok = 0; vid = 0;
    repeat (5) cyc();
    rst_n = 1;
    cyc();
    check_idle("R8 reset");

    // R1: one start condition alone does nothing
    en = 1; repeat (60) cyc(); check_idle("R1 en only");
    en = 0; uvlo_ok = 1; repeat (60) cyc(); check_idle("R1 uvlo only");

    // upward target
    vid = 8'd10; push_startup(10);
    en = 1; clr_req = 1; drain();
    n_checks++;
    if (!(pwr_good && dac_code == 10)) begin
      n_fail++; $display("FAIL R7 final: actual pg=%0b code=%0d expected 1 10", pwr_good, dac_code);
    end

    // R8: enable drop after power-good
    push(1, 0, 0, 0, 0, -1, -1, "R8"); en = 0; drain();

    // downward target, vid wiggled during hold (R5) and after capture (R6)
    vid = 8'd3; push_startup(3);
    en = 1; clr_req = 1;
    while (!(dac_code == BOOT && !ss_active && !pwm_blank)) cyc();
    vid = 8'hF0; repeat (4) cyc(); vid = 8'd3;
    while (!ss_active) cyc();
    vid = 8'h40;
    drain();
    n_checks++;
    if (dac_code != 3) begin
      n_fail++; $display("FAIL R6 capture: actual code=%0d expected 3", dac_code);
    end
    push(1, 0, 0, 0, 0, -1, -1, "R8"); en = 0; drain();

    // R9: target equals boot level
    vid = 8'(BOOT); push_startup(BOOT);
    en = 1; clr_req = 1; drain();
    push(1, 0, 0, 0, 0, -1, -1, "R8"); en = 0; drain();

    // R8: supply loss in the middle of the boot ramp
    vid = 8'd9;
    push(1, 1, 0, 0, 0, DLY, -1, "R2");
    push(0, 0, 1, 0, 0, -1, DET, "R3");
    push(0, 0, 1, 0, 1, STEP, -1, "R4");
    push(0, 0, 1, 0, 2, STEP, -1, "R4");
    push(1, 0, 0, 0, 0, -1, -1, "R8");
    en = 1; clr_req = 1;
    while (dac_code != 2) cyc();
    uvlo_ok = 0;
    drain();
    check_idle("R8 uvlo loss");

    n_checks++;
    if (q.size() != 0) begin
      n_fail++; $display("FAIL R7 leftover items: actual %0d expected 0", q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule